// File: doc/BRIEF.md
# NAND Spare-Area Sequential Read Engine

This block is the device-side logic of a byte-wide NAND flash port, limited to the spare-area read path. A host issues a spare-read command, then three address bytes. The block copies the addressed 528-byte page from a small on-chip page array into a page register. It holds its ready/busy output low for a programmable number of clock cycles while this transfer runs. After that, each falling read strobe returns the next spare byte (columns 512 to 527).

When the last spare byte has been read, the engine moves on to the following page by itself. It reloads the page register behind a fresh busy window and continues from column 512. While busy it accepts only a reset command and a status query. A separate synchronous write port fills the page array, so the contents can be set up for test.

All strobes (`we_n`, `re_n`) are sampled on the system clock and acted on at the clock edge where their transition is first seen.

Top module: `nand_spare_reader`

## Requirements
- R1: A write strobe rising edge with `ce_n` low, `cle` high and `ale` low is a command cycle. Byte 0x50 starts address capture only if `se_n` is low at that edge and the engine is not busy. With `se_n` high it is ignored, and `ry_by_n` stays high.
- R2: Three address cycles follow, each a write strobe rise with `ale` high and `cle` low. The first byte's bits [3:0] set the start column as 512 plus that value, and its bits [7:4] are ignored. The second byte and bits [5:0] of the third byte form the page number, taken modulo PAGES.
- R3: From the clock edge that takes the third address byte, `ry_by_n` is low for exactly XFER_CYCLES clock cycles, then returns high.
- R4: In the read phase with `se_n` low, each read strobe falling edge places the page-register byte at the current column on `io_out` and advances the column by one.
- R5: The read of column 527 increments the page, wrapping from PAGES-1 to 0. It then drops `ry_by_n` for XFER_CYCLES cycles counted from that edge, and reading resumes at column 512 of the new page.
- R6: While busy, only 0xFF and 0x70 commands take effect. Other command bytes, and address cycles, are ignored, and the original transfer and start column stand.
- R7: Command 0x70 enters status mode. In status mode a read strobe returns 0x40 when ready and 0x00 when busy, and does not move the column. Status mode lasts until an accepted 0x50 or a 0xFF.
- R8: Command 0xFF aborts any transfer and returns to idle, with `ry_by_n` high on the next cycle.
- R9: A read strobe outside status mode while idle, busy, or with `se_n` high drives `io_out` to 0xFF and leaves the column unchanged.
- R10: With `pre_wr` high, the byte `pre_data` is written to page `pre_page`, column `pre_col` of the array on that clock edge.
- R11: Synchronous reset puts the engine in idle with `ry_by_n` high and `io_out` at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latched on rising edge |
| re_n | input | 1 | Read strobe, acts on falling edge |
| se_n | input | 1 | Spare-area enable, active low |
| io_in | input | 8 | Command/address byte bus |
| io_out | output | 8 | Read data or status byte |
| ry_by_n | output | 1 | Ready (1) / busy (0) |
| pre_wr | input | 1 | Array preload write enable |
| pre_page | input | $clog2(PAGES) | Preload page index |
| pre_col | input | 10 | Preload column (0..527) |
| pre_data | input | 8 | Preload byte |

## Verification
The bench builds the block with PAGES=4 and XFER_CYCLES=24. Four pages are enough for the table of reads to reach the last page and show the wrap to page 0 after a rollover. A 24-cycle busy window is long enough to fit several ignored commands, a status query and a read strobe inside one transfer. It is also short enough that the exact busy length can be counted for each load.

// File: rtl/nand_spare_pkg.sv
package nand_spare_pkg;

    localparam int MAIN_BYTES  = 512;
    localparam int SPARE_BYTES = 16;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int COL_W       = $clog2(PAGE_BYTES);

    localparam logic [7:0] OP_SPARE_RD = 8'h50;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_RESET    = 8'hFF;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BUSY,
        ST_READ
    } rd_state_e;

    function automatic logic [7:0] status_byte(input logic ready);
        return {1'b0, ready, 6'b000000};
    endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b1;
        else     pin_q <= pin;
    end

    assign rise = pin & ~pin_q;
    assign fall = ~pin & pin_q;
endmodule

// File: rtl/nand_xfer_timer.sv
module nand_xfer_timer #(
    parameter int XFER_CYCLES = 350
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic done
);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort)      cnt <= '0;
        else if (start)        cnt <= CNT_W'(XFER_CYCLES);
        else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == CNT_W'(1));

    // R3: a transfer start loads the full window length
    a_r3_timer_load: assert property (@(posedge clk) disable iff (rst)
        (start && !abort) |=> (cnt == CNT_W'(XFER_CYCLES)));
endmodule

// File: rtl/nand_page_store.sv
module nand_page_store
    import nand_spare_pkg::*;
#(
    parameter int PAGES = 4,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PG_W-1:0]  wr_page,
    input  logic [COL_W-1:0] wr_col,
    input  logic [7:0]       wr_data,
    input  logic             load,
    input  logic [PG_W-1:0]  load_page,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_data
);
    logic [7:0] mem  [PAGES][PAGE_BYTES];
    logic [7:0] preg [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_page][wr_col] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (load) preg <= mem[load_page];
    end

    assign rd_data = preg[rd_col];
endmodule

// File: rtl/nand_spare_reader.sv
module nand_spare_reader
    import nand_spare_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int XFER_CYCLES = 350,
    localparam int PG_W       = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic             se_n,
    input  logic [7:0]       io_in,
    output logic [7:0]       io_out,
    output logic             ry_by_n,
    input  logic             pre_wr,
    input  logic [PG_W-1:0]  pre_page,
    input  logic [COL_W-1:0] pre_col,
    input  logic [7:0]       pre_data
);
    localparam logic [COL_W-1:0] LAST_COL  = COL_W'(PAGE_BYTES - 1);
    localparam logic [COL_W-1:0] SPARE_COL = COL_W'(MAIN_BYTES);

    rd_state_e        state;
    logic             stat_mode;
    logic [1:0]       acnt;
    logic [3:0]       a0_lo;
    logic [7:0]       a1;
    logic [PG_W-1:0]  page;
    logic [COL_W-1:0] col;

    logic we_rise, we_fall_unused, re_rise_unused, re_fall;
    logic xfer_done;
    logic [7:0] rd_data;

    nand_strobe_edge u_we (.clk(clk), .rst(rst), .pin(we_n), .rise(we_rise), .fall(we_fall_unused));
    nand_strobe_edge u_re (.clk(clk), .rst(rst), .pin(re_n), .rise(re_rise_unused), .fall(re_fall));

    logic wr_cyc, cmd_cyc, adr_cyc, re_cyc;
    logic is_reset, is_status, is_spare, addr_last, rd_ok, roll;

    always_comb begin
        wr_cyc    = we_rise & ~ce_n;
        cmd_cyc   = wr_cyc & cle & ~ale;
        adr_cyc   = wr_cyc & ale & ~cle;
        re_cyc    = re_fall & ~ce_n;
        is_reset  = cmd_cyc && (io_in == OP_RESET);
        is_status = cmd_cyc && (io_in == OP_STATUS);
        is_spare  = cmd_cyc && (io_in == OP_SPARE_RD) && !se_n && (state != ST_BUSY);
        addr_last = adr_cyc && (state == ST_ADDR) && (acnt == 2'd2);
        rd_ok     = re_cyc && !stat_mode && (state == ST_READ) && !se_n;
        roll      = rd_ok && (col == LAST_COL);
    end

    nand_xfer_timer #(.XFER_CYCLES(XFER_CYCLES)) u_timer (
        .clk(clk), .rst(rst),
        .start(addr_last | roll), .abort(is_reset),
        .done(xfer_done)
    );

    nand_page_store #(.PAGES(PAGES)) u_store (
        .clk(clk),
        .wr_en(pre_wr), .wr_page(pre_page), .wr_col(pre_col), .wr_data(pre_data),
        .load(xfer_done && state == ST_BUSY), .load_page(page),
        .rd_col(col), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            stat_mode <= 1'b0;
            acnt      <= '0;
            a0_lo     <= '0;
            a1        <= '0;
            page      <= '0;
            col       <= '0;
            io_out    <= IDLE_BYTE;
        end else begin
            if (is_reset) begin
                state     <= ST_IDLE;
                stat_mode <= 1'b0;
            end else if (is_status) begin
                stat_mode <= 1'b1;
            end else if (is_spare) begin
                state     <= ST_ADDR;
                acnt      <= '0;
                stat_mode <= 1'b0;
            end else if (adr_cyc && state == ST_ADDR) begin
                acnt <= acnt + 2'd1;
                case (acnt)
                    2'd0:    a0_lo <= io_in[3:0];
                    2'd1:    a1    <= io_in;
                    default: begin
                        page  <= PG_W'({io_in[5:0], a1} % 14'(PAGES));
                        col   <= SPARE_COL + COL_W'(a0_lo);
                        state <= ST_BUSY;
                    end
                endcase
            end else if (state == ST_BUSY && xfer_done) begin
                state <= ST_READ;
            end

            if (re_cyc) begin
                if (stat_mode) begin
                    io_out <= status_byte(state != ST_BUSY);
                end else if (rd_ok) begin
                    io_out <= rd_data;
                    if (roll) begin
                        col   <= SPARE_COL;
                        page  <= (page == PG_W'(PAGES - 1)) ? '0 : page + PG_W'(1);
                        state <= ST_BUSY;
                    end else begin
                        col <= col + COL_W'(1);
                    end
                end else begin
                    io_out <= IDLE_BYTE;
                end
            end
        end
    end

    assign ry_by_n = (state != ST_BUSY);

    a_r4_col_step: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && col != LAST_COL) |=> (col == $past(col) + COL_W'(1)));

    a_r5_roll_restart: assert property (@(posedge clk) disable iff (rst)
        roll |=> (!ry_by_n && col == SPARE_COL));

    a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && !xfer_done && !is_reset) |=> (state == ST_BUSY));

    a_r8_reset_release: assert property (@(posedge clk) disable iff (rst)
        is_reset |=> ry_by_n);

    a_r9_busy_fixed: assert property (@(posedge clk) disable iff (rst)
        (re_fall && !ce_n && !ry_by_n && !stat_mode) |=> (io_out == IDLE_BYTE));
endmodule

// File: tb/tb_nand_spare_reader.sv
module tb_nand_spare_reader;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES = 4;
    localparam int XFER  = 24;
    // page in [15:8], first address byte in [7:0]
    localparam logic [15:0] VEC [4] = '{16'h0000, 16'h01F5, 16'h020F, 16'h0309};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, se_n = 1'b0;
    logic [7:0] io_in = '0;
    logic [7:0] io_out;
    logic ry_by_n;
    logic pre_wr = 1'b0;
    logic [1:0] pre_page = '0;
    logic [9:0] pre_col = '0;
    logic [7:0] pre_data = '0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rb;
    int n;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_spare_reader #(.PAGES(PAGES), .XFER_CYCLES(XFER)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .se_n(se_n), .io_in(io_in), .io_out(io_out), .ry_by_n(ry_by_n),
        .pre_wr(pre_wr), .pre_page(pre_page), .pre_col(pre_col), .pre_data(pre_data)
    );

    function automatic logic [7:0] pat(int p, int c);
        return 8'((p * 37 + c * 5) ^ 60);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic wr_byte(logic c, logic a, logic [7:0] d);
        cle = c; ale = a; io_in = d; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic re_pulse(output logic [7:0] d);
        re_n = 1'b0;
        @(negedge clk);
        d = io_out;
        re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_read(int p, logic [7:0] lo);
        wr_byte(1'b1, 1'b0, 8'h50);
        wr_byte(1'b0, 1'b1, lo);
        wr_byte(1'b0, 1'b1, 8'(p));
        wr_byte(1'b0, 1'b1, 8'h00);
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!ry_by_n && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after reset", int'(ry_by_n), 1);
        chk("R11 idle byte after reset", int'(io_out), 8'hFF);

        // R10: preload the array through the write port
        pre_wr = 1'b1;
        for (int p = 0; p < PAGES; p++) begin
            for (int c = 0; c < 528; c++) begin
                pre_page = 2'(p); pre_col = 10'(c); pre_data = pat(p, c);
                @(negedge clk);
            end
        end
        pre_wr = 1'b0;

        // table of reads: R1 R2 R3 R4 R5
        for (int v = 0; v < 4; v++) begin
            int pg, st, nx;
            pg = int'(VEC[v][15:8]);
            st = int'(VEC[v][3:0]);
            nx = (pg + 1) % PAGES;
            start_read(pg, VEC[v][7:0]);
            chk("R1 busy after command", int'(ry_by_n), 0);
            wait_ready(n);
            chk("R3 busy length", n, XFER);
            for (int c = 512 + st; c < 528; c++) begin
                re_pulse(rb);
                chk("R4 spare byte (R2 start)", int'(rb), int'(pat(pg, c)));
            end
            chk("R5 busy after col 527", int'(ry_by_n), 0);
            wait_ready(n);
            chk("R5 rollover busy length", n, XFER - 1);
            for (int c = 512; c < 515; c++) begin
                re_pulse(rb);
                chk("R5 next page from col 512", int'(rb), int'(pat(nx, c)));
            end
        end

        // R10: overwrite one byte and read it back
        pre_wr = 1'b1; pre_page = 2'd1; pre_col = 10'd520; pre_data = 8'h5A;
        @(negedge clk);
        pre_wr = 1'b0;
        start_read(1, 8'h08);
        wait_ready(n);
        re_pulse(rb);
        chk("R10 preloaded byte", int'(rb), 8'h5A);

        // R8 then R1: command ignored with se_n high
        wr_byte(1'b1, 1'b0, 8'hFF);
        se_n = 1'b1;
        start_read(0, 8'h00);
        chk("R1 se_n high keeps ready", int'(ry_by_n), 1);
        re_pulse(rb);
        chk("R9 idle read gives 0xFF", int'(rb), 8'hFF);
        se_n = 1'b0;

        // R9: strobe while busy and with se_n high
        start_read(2, 8'h04);
        re_pulse(rb);
        chk("R9 busy read gives 0xFF", int'(rb), 8'hFF);
        wait_ready(n);
        se_n = 1'b1;
        re_pulse(rb);
        chk("R9 se_n high read gives 0xFF", int'(rb), 8'hFF);
        se_n = 1'b0;
        re_pulse(rb);
        chk("R9 column unchanged", int'(rb), int'(pat(2, 516)));

        // R6: ignored command and address during busy
        start_read(1, 8'h02);
        wr_byte(1'b1, 1'b0, 8'h00);
        wr_byte(1'b1, 1'b0, 8'h50);
        wr_byte(1'b0, 1'b1, 8'h07);
        chk("R6 still busy", int'(ry_by_n), 0);
        wait_ready(n);
        re_pulse(rb);
        chk("R6 original start kept", int'(rb), int'(pat(1, 514)));

        // R7: status during busy and ready
        start_read(3, 8'h00);
        wr_byte(1'b1, 1'b0, 8'h70);
        re_pulse(rb);
        chk("R7 status busy", int'(rb), 8'h00);
        wait_ready(n);
        re_pulse(rb);
        chk("R7 status ready", int'(rb), 8'h40);
        start_read(3, 8'h00);
        wait_ready(n);
        re_pulse(rb);
        chk("R7 status cleared by 0x50", int'(rb), int'(pat(3, 512)));

        // R8: reset command during busy
        start_read(0, 8'h03);
        @(negedge clk);
        wr_byte(1'b1, 1'b0, 8'hFF);
        chk("R8 ready after reset cmd", int'(ry_by_n), 1);
        re_pulse(rb);
        chk("R8 idle after reset cmd", int'(rb), 8'hFF);

        // R11: synchronous reset during busy
        start_read(2, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after mid reset", int'(ry_by_n), 1);
        chk("R11 idle byte after mid reset", int'(io_out), 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule